// File: doc/BRIEF.md
# Triangular Spread Profile Generator

This block drives the fractional-N control of a frequency synthesizer with a signed offset word, so that the synthesized clock sweeps back and forth around its nominal frequency and spreads its emitted energy. It runs from the reference clock and produces a new offset every reference cycle. The offset is expressed in thousandths of a percent, so a value of -5000 means the synthesizer runs 5.0% below nominal.

Three static inputs configure the sweep. A spread code picks the total span, a mode bit picks the sweep shape, and a period count sets the number of reference cycles in one modulation period. The period count is chosen as the reference frequency divided by roughly 31.5 kHz, so the modulation rate stays the same whatever output frequency is synthesized. In center mode the offset swings between plus and minus half the span. In down mode it swings between zero and minus the full span, so it never rises above nominal. An active-low enable input starts and stops the sweep. Both starting and stopping happen only at a zero-offset point, so the synthesizer never sees a jump. A one-cycle strobe marks the top of every triangle.

Top module: `ssc_profile_gen`

## Requirements
- R1: While reset is applied and in the first cycles after it, `freq_offset` is 0, `period_start` is 0 and `config_error` is 0.
- R2: Spread codes 0 to 18 are legal and select a total span of S = 500 + 250*code units (0.5% to 5.0% in 0.25% steps).
- R3: In center mode (`down_spread`=0) the offset is +S/2 in the cycle `period_start` is high and -S/2 exactly half a period later.
- R4: In down mode (`down_spread`=1) the offset is 0 in the cycle `period_start` is high, is -S half a period later, and never exceeds 0 or falls below -S.
- R5: With H the half period and k the cycles since the last strobe, the offset is top - floor(S*k/H) for k < H, and bottom + floor(S*(k-H)/H) for k >= H. Top and bottom are the peaks of R3 or R4.
- R6: The modulation period is N = 2H cycles, where H = 2*floor(`mod_period`/4); the two low bits of `mod_period` are ignored. `period_start` is high for exactly one cycle per period.
- R7: `spread_en_n` is active low (0 = sweep on, 1 = off) and passes through a two-flop synchronizer. A sweep starts at a zero-offset point on its falling slope: mid-fall in center mode, at the top in down mode. Its first nonzero offset is therefore negative and no larger in size than floor(S/H)+1.
- R8: After `spread_en_n` rises, the sweep continues along its profile until the offset reaches 0 at or after the second sample following the request. From the next cycle the offset is exactly 0 and `period_start` stays low.
- R9: A spread code of 19 to 31 forces the offset to 0 with no strobes. `config_error` rises on the next cycle and stays high until reset, even after the code returns to a legal value.
- R10: While sweeping, the offset changes by at most floor(S/H)+1 from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spread_en_n | input | 1 | Sweep enable, active low, asynchronous |
| down_spread | input | 1 | 1 = down mode, 0 = center mode |
| spread_code | input | CODE_W | Span select, legal 0..18 |
| mod_period | input | CNT_W | Reference cycles per modulation period, multiple of 4 |
| freq_offset | output | OFS_W | Signed offset in units of 0.001% |
| period_start | output | 1 | One-cycle strobe at the top of each triangle |
| config_error | output | 1 | Sticky flag for an illegal spread code |

## Verification
The bench compares every sample of whole periods against a floor-based formula. A generator that loses the fractional remainder of the per-cycle step would drift away from the peaks and miss -S or -S/2 at mid-period. The bench times the stop request so that a zero-offset point falls in the two-cycle synchronizer window. A design that stops at the wrong zero, or cuts the sweep off at once, then shows either a jump or an offset that disagrees with the profile. It sets a period count with nonzero low bits, which exposes a design that uses those bits. It also returns an illegal code to a legal one, which separates a sticky error flag from a live one.

// File: rtl/ssc_prof_pkg.sv
package ssc_prof_pkg;
  localparam int unsigned LAST_CODE  = 18;
  localparam int unsigned SPAN_BASE  = 500;
  localparam int unsigned SPAN_STEP  = 250;

  function automatic logic code_ok(input int unsigned code);
    return code <= LAST_CODE;
  endfunction

  function automatic int unsigned span_units(input int unsigned code);
    return SPAN_BASE + SPAN_STEP * code;
  endfunction
endpackage

// File: rtl/ssc_level_sync.sv
module ssc_level_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b1;
        else if (i == 0) chain[i] <= d_async;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/ssc_step_div.sv
module ssc_step_div #(
  parameter int W = 16
) (
  input  logic [W-1:0] span,
  input  logic [W-1:0] half,
  output logic [W-1:0] step_q,
  output logic [W-1:0] step_r
);
  always_comb begin
    if (half == '0) begin
      step_q = '0;
      step_r = '0;
    end else begin
      step_q = span / half;
      step_r = span % half;
    end
  end
endmodule

// File: rtl/ssc_sweep_core.sv
module ssc_sweep_core #(
  parameter int CNT_W = 16,
  parameter int OFS_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run_req,
  input  logic                    legal,
  input  logic                    down,
  input  logic [CNT_W-1:0]        span,
  input  logic [CNT_W-1:0]        half,
  input  logic [CNT_W-1:0]        step_q,
  input  logic [CNT_W-1:0]        step_r,
  output logic signed [OFS_W-1:0] offset,
  output logic                    strobe,
  output logic                    active
);
  logic [CNT_W-1:0]        cnt, mag, frac;
  logic [CNT_W-1:0]        cnt_nxt, last_cnt;
  logic [CNT_W:0]          frac_sum;
  logic                    wrap, falling;
  logic signed [OFS_W-1:0] span_s, top_v, bot_v, mag_s;

  always_comb begin
    span_s   = $signed(OFS_W'(span));
    mag_s    = $signed(OFS_W'(mag));
    top_v    = down ? '0 : (span_s >>> 1);
    bot_v    = down ? -span_s : -(span_s >>> 1);
    falling  = cnt < half;
    offset   = !active ? '0 : (falling ? top_v - mag_s : bot_v + mag_s);
    last_cnt = (half << 1) - 1'b1;
    cnt_nxt  = (cnt == last_cnt) ? '0 : cnt + 1'b1;
    frac_sum = {1'b0, frac} + {1'b0, step_r};
    wrap     = frac_sum >= {1'b0, half};
  end

  assign strobe = active && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      mag    <= '0;
      frac   <= '0;
    end else if (!active) begin
      if (run_req && legal) begin
        active <= 1'b1;
        cnt    <= down ? '0 : (half >> 1);
        mag    <= down ? '0 : (span >> 1);
        frac   <= '0;
      end
    end else if (!legal || (!run_req && offset == '0)) begin
      active <= 1'b0;
      cnt    <= '0;
      mag    <= '0;
      frac   <= '0;
    end else begin
      cnt <= cnt_nxt;
      if (cnt_nxt == '0 || cnt_nxt == half) begin
        mag  <= '0;
        frac <= '0;
      end else if (wrap) begin
        mag  <= mag + step_q + 1'b1;
        frac <= CNT_W'(frac_sum - {1'b0, half});
      end else begin
        mag  <= mag + step_q;
        frac <= CNT_W'(frac_sum);
      end
    end
  end
endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen #(
  parameter int CODE_W = 5,
  parameter int CNT_W  = 16,
  parameter int OFS_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    spread_en_n,
  input  logic                    down_spread,
  input  logic [CODE_W-1:0]       spread_code,
  input  logic [CNT_W-1:0]        mod_period,
  output logic signed [OFS_W-1:0] freq_offset,
  output logic                    period_start,
  output logic                    config_error
);
  localparam int SYNC_STAGES = 2;

  logic             off_sync, code_legal, sweep_active;
  logic [CNT_W-1:0] span_units_w, half_w, step_q_w, step_r_w;

  assign code_legal   = ssc_prof_pkg::code_ok(int'(spread_code));
  assign span_units_w = code_legal ? CNT_W'(ssc_prof_pkg::span_units(int'(spread_code))) : '0;
  assign half_w       = {1'b0, mod_period[CNT_W-1:2], 1'b0};

  ssc_level_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(spread_en_n), .q_sync(off_sync)
  );

  ssc_step_div #(.W(CNT_W)) u_div (
    .span(span_units_w), .half(half_w), .step_q(step_q_w), .step_r(step_r_w)
  );

  ssc_sweep_core #(.CNT_W(CNT_W), .OFS_W(OFS_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run_req(!off_sync), .legal(code_legal),
    .down(down_spread), .span(span_units_w), .half(half_w),
    .step_q(step_q_w), .step_r(step_r_w),
    .offset(freq_offset), .strobe(period_start), .active(sweep_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) config_error <= 1'b0;
    else if (!code_legal) config_error <= 1'b1;
  end
endmodule

// File: rtl/ssc_profile_chk.sv
module ssc_profile_chk #(
  parameter int CNT_W = 16,
  parameter int OFS_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic signed [OFS_W-1:0] off,
  input logic                    strobe,
  input logic                    cfg_err,
  input logic                    active,
  input logic                    legal,
  input logic                    down,
  input logic [CNT_W-1:0]        span,
  input logic [CNT_W-1:0]        step_q
);
  int off_i, span_i, q_i;
  always_comb begin
    off_i  = int'(off);
    span_i = int'(span);
    q_i    = int'(step_q);
  end

  assert_center_peak_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !down) |-> (off_i == span_i / 2));

  assert_down_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && down) |-> (off_i <= 0 && off_i >= -span_i));

  assert_down_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && down) |-> (off_i == 0));

  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  assert_stop_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(active) && $past(legal)) |-> ($past(off_i) == 0));

  assert_err_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !legal |=> cfg_err);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  assert_step_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && $stable(span)) |->
      ((off_i - $past(off_i) <= q_i + 1) && ($past(off_i) - off_i <= q_i + 1)));
endmodule

bind ssc_profile_gen ssc_profile_chk #(.CNT_W(CNT_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .off(freq_offset), .strobe(period_start),
  .cfg_err(config_error), .active(sweep_active), .legal(code_legal),
  .down(down_spread), .span(span_units_w), .step_q(step_q_w)
);

// File: tb/sim_ssc_profile_gen.sv
module sim_ssc_profile_gen;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               spread_en_n = 1'b1;
  logic               down_spread = 1'b0;
  logic [4:0]         spread_code = '0;
  logic [15:0]        mod_period = 16'd40;
  logic signed [15:0] freq_offset;
  logic               period_start, config_error;
  int checks = 0, errors = 0;
  bit done = 0;

  ssc_profile_gen u0 (
    .clk(clk), .rst_n(rst_n), .spread_en_n(spread_en_n), .down_spread(down_spread),
    .spread_code(spread_code), .mod_period(mod_period), .freq_offset(freq_offset),
    .period_start(period_start), .config_error(config_error)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  function automatic int exp_off(input bit dn, input int s, input int h, input int k);
    int top, bot;
    top = dn ? 0 : s / 2;
    bot = dn ? -s : -(s / 2);
    if (k < h) return top - (s * k) / h;
    return bot + (s * (k - h)) / h;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) step();
    chk(freq_offset == 0, "R1 offset in reset", int'(freq_offset), 0);
    chk(period_start == 0 && config_error == 0, "R1 flags in reset",
        int'({period_start, config_error}), 0);
    rst_n = 1'b1;
    step();
    chk(freq_offset == 0 && period_start == 0 && config_error == 0, "R1 after release",
        int'(freq_offset), 0);
  endtask

  task automatic t_sweep(input bit dn, input int code, input int period, input int nper);
    int s, h, n, qb, prev, cur, k, km, e;
    bit seen_nz, found, stopped;
    spread_en_n = 1'b1;
    down_spread = dn;
    spread_code = 5'(code);
    mod_period  = 16'(period);
    repeat (4) step();
    s = 500 + 250 * code;
    h = (period / 4) * 2;
    n = 2 * h;
    qb = s / h + 1;
    spread_en_n = 1'b0;
    prev = 0; seen_nz = 0; found = 0;
    for (int i = 0; i < 2 * n + 10 && !found; i++) begin
      step();
      cur = int'(freq_offset);
      if (!seen_nz && cur != 0) begin
        seen_nz = 1;
        chk(cur < 0 && -cur <= qb, "R7 first step from zero", cur, -qb);
      end else if (seen_nz) begin
        chk(cur - prev <= qb && prev - cur <= qb, "R10 step bound", cur - prev, qb);
      end
      if (period_start) found = 1;
      prev = cur;
    end
    chk(found, "R6 strobe appears", int'(found), 1);
    chk(int'(freq_offset) == exp_off(dn, s, h, 0), dn ? "R4 top" : "R3 top",
        int'(freq_offset), exp_off(dn, s, h, 0));
    k = 0;
    for (int i = 1; i <= nper * n; i++) begin
      step();
      k++;
      km = k % n;
      e = exp_off(dn, s, h, km);
      chk(int'(freq_offset) == e, "R5 profile sample", int'(freq_offset), e);
      chk(period_start == (km == 0), "R6 strobe timing", int'(period_start), int'(km == 0));
      if (km == h)
        chk(int'(freq_offset) == (dn ? -s : -(s / 2)), dn ? "R2 R4 bottom" : "R2 R3 bottom",
            int'(freq_offset), dn ? -s : -(s / 2));
      if (dn) chk(freq_offset <= 0, "R4 never above nominal", int'(freq_offset), 0);
    end
    spread_en_n = 1'b1;
    stopped = 0;
    for (int j = 1; j <= n + 10; j++) begin
      step();
      k++;
      km = k % n;
      if (!stopped) begin
        e = exp_off(dn, s, h, km);
        chk(int'(freq_offset) == e, "R8 continue until zero", int'(freq_offset), e);
        chk(period_start == (km == 0), "R8 strobe while draining", int'(period_start),
            int'(km == 0));
        if (e == 0 && j >= 2) stopped = 1;
      end else begin
        chk(freq_offset == 0 && !period_start, "R8 held at nominal", int'(freq_offset), 0);
      end
    end
    chk(stopped, "R8 sweep stopped", int'(stopped), 1);
  endtask

  task automatic t_illegal();
    bit found;
    spread_en_n = 1'b1;
    down_spread = 1'b0;
    mod_period  = 16'd40;
    spread_code = 5'd25;
    repeat (2) step();
    chk(config_error == 1, "R9 error set", int'(config_error), 1);
    spread_en_n = 1'b0;
    for (int i = 0; i < 100; i++) begin
      step();
      chk(freq_offset == 0 && !period_start, "R9 illegal code gives no sweep",
          int'(freq_offset), 0);
    end
    spread_code = 5'd3;
    found = 0;
    for (int i = 0; i < 100; i++) begin
      step();
      if (period_start) found = 1;
    end
    chk(config_error == 1, "R9 error sticky", int'(config_error), 1);
    chk(found, "R9 legal code sweeps again", int'(found), 1);
    spread_en_n = 1'b1;
    do_reset();
    chk(config_error == 0, "R9 error cleared by reset", int'(config_error), 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_sweep(1'b0, 0, 40, 2);
    t_sweep(1'b1, 18, 3968, 2);
    t_sweep(1'b0, 5, 43, 2);
    t_sweep(1'b1, 7, 100, 2);
    t_sweep(1'b0, 18, 3968, 1);
    t_illegal();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule